// File: doc/BRIEF.md
# Double-Buffered Conversion Result Store

This block keeps the latest conversion results of up to eight logical channels so that a host can read them while the converter keeps producing new ones. Each channel owns two 16-bit result slots with their own read and write pointers. The host always reads the slot under the read pointer. New results go to the slot under the write pointer.

If a result is still waiting to be read, the read pointer stays on it. Later conversions then land in the other slot, and each one overwrites the one before it. The host therefore gets the oldest unread result first and the newest one next. Any results in between are dropped.

A scan is the converter writing channels 0, 1, ... up to the last active channel. The write to the last active channel raises an end-of-scan flag. The flag drops once the host has read every active channel, or when the converter starts the next scan by writing channel 0.

Top module: `res_store`

## Requirements
- R1: After reset, every slot of every channel is empty and holds 0, both pointers are 0, `eos_o` is 0 and `rd_data_o` is 0. A read of a channel that was never written returns 0.
- R2: A read strobe on channel c puts the result under c's read pointer on `rd_data_o` one clock edge after the strobe. `rd_data_o` keeps that value until the next read strobe.
- R3: If a channel receives two results before a read, its first read returns the older result and its second read returns the newer one.
- R4: If a channel receives three or more results before a read, its first read returns the oldest result. Its second read returns the newest result, and every result in between is lost.
- R5: A read frees the slot just read. A result written after all pending results have been read is returned by the next read.
- R6: A read when no unread result is pending returns the last result read again and does not change any pointer.
- R7: `act_cnt_i` gives the number of active channels minus one (value 0 means 1 channel, value 7 means 8 channels). A write to channel `act_cnt_i` sets `eos_o` one clock edge later. Writes to lower channels do not set it.
- R8: While `eos_o` is high, once reads have covered every channel from 0 to `act_cnt_i`, `eos_o` goes low one edge after the last of those reads. If a scan-completing write happens on the same edge, `eos_o` stays high.
- R9: When `act_cnt_i` is not 0, a write to channel 0 clears `eos_o` on the next edge, because it starts a new scan.
- R10: Channels are independent. Writes and reads on one channel do not change the results stored for any other channel.
- R11: If a read and a write hit the same channel on the same edge, the read is served first and returns the previously readable result. The written result is returned by a later read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Result write strobe |
| wr_ch_i | input | 3 | Channel of the result being written |
| wr_data_i | input | 16 | Result value |
| rd_en_i | input | 1 | Host read strobe |
| rd_ch_i | input | 3 | Channel being read |
| rd_data_o | output | 16 | Result returned by the last read |
| act_cnt_i | input | 3 | Active channel count minus one |
| eos_o | output | 1 | End of scan flag |

## Verification
Every result is due one edge after its strobe. `rd_data_o` is registered on the edge that takes `rd_en_i`. `eos_o` changes on the edge that takes the completing write, the starting write, or the covering read. The bench drives each strobe on a falling edge for exactly one cycle and compares at the next falling edge, so the edge that updates the result sits exactly halfway between. The bench sweeps all eight channel counts, one full scan each, and runs the overrun, freeing and same-cycle sequences on every channel. Expected values come from a formula over channel and step.

// File: rtl/res_store_pkg.sv
package res_store_pkg;
  typedef struct packed {
    logic       rd_ptr;
    logic       wr_ptr;
    logic [1:0] unread;
  } slot_stat_t;
endpackage

// File: rtl/res_slot.sv
module res_slot
  import res_store_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] q_o,
  output slot_stat_t    stat_o
);
  logic [DW-1:0] mem_q [2];
  logic          rd_q, wr_q;
  logic [1:0]    un_q;
  logic          rd_d, wr_d;
  logic [1:0]    un_d, un_rd;

  // read is served before write on the same edge
  always_comb begin
    rd_d = rd_q;
    wr_d = wr_q;
    un_d = un_q;
    if (rd_en_i) begin
      un_d[rd_q] = 1'b0;
      if (un_q[!rd_q]) begin
        rd_d = !rd_q;
        wr_d = rd_q;
      end
    end
    un_rd = un_d;
    if (wr_en_i) begin
      un_d[wr_d] = 1'b1;
      if (!un_rd[rd_d]) begin
        rd_d = wr_d;
        wr_d = !wr_d;
      end
    end
  end

  // write slot: pointer after the read step
  logic wsel;
  always_comb begin
    wsel = wr_q;
    if (rd_en_i && un_q[!rd_q]) wsel = rd_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q     <= 1'b0;
      wr_q     <= 1'b0;
      un_q     <= '0;
      mem_q[0] <= '0;
      mem_q[1] <= '0;
    end else begin
      rd_q <= rd_d;
      wr_q <= wr_d;
      un_q <= un_d;
      if (wr_en_i) mem_q[wsel] <= wr_data_i;
    end
  end

  assign q_o    = mem_q[rd_q];
  assign stat_o = '{rd_ptr: rd_q, wr_ptr: wr_q, unread: un_q};
endmodule

// File: rtl/res_eos.sv
module res_eos #(
  parameter int N_CH = 8,
  parameter int CW   = $clog2(N_CH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [CW-1:0] wr_ch_i,
  input  logic          rd_en_i,
  input  logic [CW-1:0] rd_ch_i,
  input  logic [CW-1:0] act_cnt_i,
  output logic          eos_o
);
  logic [N_CH-1:0] seen_q, seen_nx, act_mask;
  logic            eos_q, scan_end, scan_start;

  always_comb begin
    for (int i = 0; i < N_CH; i++) act_mask[i] = (i <= int'(act_cnt_i));
    seen_nx = seen_q;
    if (rd_en_i) seen_nx[rd_ch_i] = 1'b1;
  end

  assign scan_end   = wr_en_i && (wr_ch_i == act_cnt_i);
  assign scan_start = wr_en_i && (wr_ch_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eos_q  <= 1'b0;
      seen_q <= '0;
    end else if (scan_end) begin
      eos_q  <= 1'b1;
      seen_q <= '0;
    end else if (scan_start) begin
      eos_q  <= 1'b0;
      seen_q <= '0;
    end else if (eos_q && ((seen_nx & act_mask) == act_mask)) begin
      eos_q  <= 1'b0;
      seen_q <= '0;
    end else if (eos_q) begin
      seen_q <= seen_nx;
    end
  end

  assign eos_o = eos_q;
endmodule

// File: rtl/res_store.sv
module res_store
  import res_store_pkg::*;
#(
  parameter int N_CH = 8,
  parameter int DW   = 16,
  parameter int CW   = $clog2(N_CH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [CW-1:0] wr_ch_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic [CW-1:0] rd_ch_i,
  output logic [DW-1:0] rd_data_o,
  input  logic [CW-1:0] act_cnt_i,
  output logic          eos_o
);
  logic [DW-1:0]   slot_q [N_CH];
  slot_stat_t      slot_stat [N_CH];

  for (genvar c = 0; c < N_CH; c++) begin : g_slot
    res_slot #(.DW(DW)) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_en_i && (wr_ch_i == CW'(c))),
      .wr_data_i(wr_data_i),
      .rd_en_i  (rd_en_i && (rd_ch_i == CW'(c))),
      .q_o      (slot_q[c]),
      .stat_o   (slot_stat[c])
    );
  end

  res_eos #(.N_CH(N_CH), .CW(CW)) u_eos (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_ch_i  (wr_ch_i),
    .rd_en_i  (rd_en_i),
    .rd_ch_i  (rd_ch_i),
    .act_cnt_i(act_cnt_i),
    .eos_o    (eos_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= slot_q[rd_ch_i];
  end
endmodule

// File: rtl/res_store_chk.sv
module res_store_chk
  import res_store_pkg::*;
#(
  parameter int N_CH = 8,
  parameter int CW   = $clog2(N_CH)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [CW-1:0] wr_ch_i,
  input logic          rd_en_i,
  input logic [CW-1:0] rd_ch_i,
  input logic [CW-1:0] act_cnt_i,
  input logic          eos_o,
  input slot_stat_t    slot_stat [N_CH]
);
  AST_EOS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (wr_ch_i == act_cnt_i) |=> eos_o); // R7

  AST_EOS_NEWSCAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (wr_ch_i == '0) && (act_cnt_i != '0) |=> !eos_o); // R9

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    AST_NO_ORPHAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(slot_stat[c].unread[slot_stat[c].wr_ptr] &&
        !slot_stat[c].unread[slot_stat[c].rd_ptr])); // R4

    AST_HOLD_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && (wr_ch_i == CW'(c)) && !(rd_en_i && (rd_ch_i == CW'(c))) &&
      slot_stat[c].unread[slot_stat[c].rd_ptr] |=> $stable(slot_stat[c].rd_ptr)); // R4

    AST_READ_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_en_i && (rd_ch_i == CW'(c)) && !wr_en_i &&
      !slot_stat[c].unread[!slot_stat[c].rd_ptr] |=> (slot_stat[c].unread == 2'b00)); // R5

    AST_IDLE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_en_i && (rd_ch_i == CW'(c)) && !wr_en_i && (slot_stat[c].unread == 2'b00)
      |=> $stable(slot_stat[c].rd_ptr) && $stable(slot_stat[c].wr_ptr)); // R6
  end
endmodule

bind res_store res_store_chk #(.N_CH(N_CH), .CW(CW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_ch_i  (wr_ch_i),
  .rd_en_i  (rd_en_i),
  .rd_ch_i  (rd_ch_i),
  .act_cnt_i(act_cnt_i),
  .eos_o    (eos_o),
  .slot_stat(slot_stat)
);

// File: tb/tb_res_store.sv
`timescale 1ns/1ps
module tb_res_store;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [2:0]  wr_ch_i = '0, rd_ch_i = '0, act_cnt_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] rd_data_o;
  logic        eos_o;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #10 clk_i = ~clk_i;

  res_store dut (.*);

  function automatic logic [15:0] val(int a, int b, int c);
    return 16'((a * 4096) + (b * 256) + (c * 17) + 3);
  endfunction

  task automatic chk16(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk1(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(int ch, logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_ch_i = 3'(ch); wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(int ch, output logic [15:0] q);
    @(negedge clk_i);
    rd_en_i = 1'b1; rd_ch_i = 3'(ch);
    @(negedge clk_i);
    rd_en_i = 1'b0;
    q = rd_data_o;
  endtask

  task automatic rdwr(int ch, logic [15:0] d, output logic [15:0] q);
    @(negedge clk_i);
    rd_en_i = 1'b1; rd_ch_i = 3'(ch);
    wr_en_i = 1'b1; wr_ch_i = 3'(ch); wr_data_i = d;
    @(negedge clk_i);
    rd_en_i = 1'b0; wr_en_i = 1'b0;
    q = rd_data_o;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] q;
    repeat (3) @(negedge clk_i);
    chk16("R1 rd_data after reset", rd_data_o, 16'h0);
    chk1("R1 eos after reset", eos_o, 1'b0);
    rst_ni = 1'b1;
    for (int ch = 0; ch < 8; ch++) begin
      rd(ch, q);
      chk16("R1 empty read", q, 16'h0);
    end

    // R7 R8 R2 R10: full scan for every active count
    for (int n = 0; n < 8; n++) begin
      act_cnt_i = 3'(n);
      for (int ch = 0; ch <= n; ch++) begin
        wr(ch, val(n, ch, 1));
        chk1("R7 eos after write", eos_o, ch == n);
      end
      for (int ch = n; ch >= 0; ch--) begin
        rd(ch, q);
        chk16("R2 R10 scan read", q, val(n, ch, 1));
        chk1("R8 eos after read", eos_o, ch != 0);
      end
    end

    // R3 R4 R5 R6 R11 on every channel
    act_cnt_i = 3'd7;
    for (int ch = 0; ch < 8; ch++) begin
      wr(ch, val(ch, 1, 2));
      wr(ch, val(ch, 2, 2));
      rd(ch, q); chk16("R3 older first", q, val(ch, 1, 2));
      rd(ch, q); chk16("R3 newer second", q, val(ch, 2, 2));
      wr(ch, val(ch, 3, 2));
      wr(ch, val(ch, 4, 2));
      wr(ch, val(ch, 5, 2));
      rd(ch, q); chk16("R4 oldest kept", q, val(ch, 3, 2));
      rd(ch, q); chk16("R4 newest survives", q, val(ch, 5, 2));
      rd(ch, q); chk16("R6 repeat read", q, val(ch, 5, 2));
      wr(ch, val(ch, 6, 2));
      rd(ch, q); chk16("R5 freed slot reused", q, val(ch, 6, 2));
      rdwr(ch, val(ch, 7, 2), q); chk16("R11 read first", q, val(ch, 6, 2));
      rd(ch, q); chk16("R11 write later", q, val(ch, 7, 2));
    end
    // R10: earlier channels untouched by later activity
    for (int ch = 0; ch < 8; ch++) begin
      rd(ch, q); chk16("R10 channel isolation", q, val(ch, 7, 2));
    end

    // R9: new scan clears eos
    act_cnt_i = 3'd3;
    for (int ch = 0; ch <= 3; ch++) wr(ch, val(9, ch, 3));
    chk1("R9 eos set before restart", eos_o, 1'b1);
    wr(0, val(9, 0, 4));
    chk1("R9 eos cleared by new scan", eos_o, 1'b0);
    for (int ch = 1; ch <= 3; ch++) wr(ch, val(9, ch, 4));
    chk1("R7 eos set again", eos_o, 1'b1);
    rd(0, q); chk16("R4 pending kept at restart", q, val(9, 0, 3));
    chk1("R8 partial reads keep eos", eos_o, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule